// File: doc/BRIEF.md
# Serial EEPROM-Style SPI Slave

This block is an SPI slave that acts like a small serial EEPROM. A master selects it with an active-low select, clocks it in SPI mode 0 and talks to it with one-byte commands. Some commands need no further bytes: they set or clear the write-enable latch. Others read or write an 8-bit status register, or read or write a 256-byte storage array after an 8-bit address. All pins are sampled by the block's system clock through a synchronizer, and SPI clock edges are found from the sampled level. The serial clock must therefore run well below the system clock.

Writes are staged. Data bytes go into a page buffer. When the select is released on a byte boundary, an internal programming cycle starts, provided the write-protect pin is high and the write-enable latch is set. The programming cycle is a countdown of a fixed number of system clocks. At its end the buffered data reach the array or the status register, and the busy and write-enable flags both clear. Two status bits choose a protected region of the array, and bytes in that region are never written. An active-low hold input pauses a transfer in mid-sequence without losing its place.

Top module: `spi_eeprom_slave`

## Requirements
- R1: While select is high the block ignores SCK and SO is 0. Raising select abandons any sequence in progress, and the next selection starts with a fresh command byte.
- R2: SI is taken on each rising SCK edge and SO changes only after a falling SCK edge. Every command, address and data byte travels most significant bit first.
- R3: The command bytes are 0x06 (set write enable), 0x04 (clear write enable), 0x05 (read status), 0x01 (write status), 0x03 (read array) and 0x02 (write array). Any other command byte changes nothing.
- R4: A status read returns the byte {4'b0000, P1, P0, WE, BUSY}. P1:P0 is in bits 3:2, the write-enable latch is in bit 1 and the busy flag is in bit 0. Bits 7:4 always read 0. The status byte repeats for as long as the read continues.
- R5: While write-protect is low, no array write and no status write starts a programming cycle.
- R6: While the write-enable latch is 0, no array write and no status write starts a programming cycle.
- R7: Protected region by P1:P0: 00 protects nothing, 01 protects 0xC0-0xFF, 10 protects 0x80-0xFF and 11 protects the whole array. Bytes aimed at the protected region stay unchanged, while the other bytes of the same write are stored.
- R8: A write starts programming only when select rises after a whole number of data bytes (at least one). Busy then reads 1 for PROG_CYCLES clocks. At the end the data is stored and busy and the write-enable latch both read 0. A write cut off in the middle of a byte stores nothing.
- R9: Write-protect going low after a programming cycle has started does not stop that cycle from storing its data.
- R10: While hold is low, SCK edges are ignored and the position within the sequence is frozen. When hold returns high, the transfer continues from where it stopped.
- R11: An array read returns bytes from consecutive addresses for as long as select stays low, wrapping from 0xFF to 0x00.
- R12: While busy is 1, every command except the status read is ignored.
- R13: One write keeps at most PAGE_BYTES data bytes, stored at the start address and the addresses that follow it, wrapping at 0xFF. Bytes after the first PAGE_BYTES are dropped.
- R14: Status reads, array reads and the two write-enable commands work whatever the level of write-protect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low device select |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause of the current transfer |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out of the block |

## Verification
The assertions assume that the master changes SCK, SI and select slowly enough for every level to pass the synchronizer. They also assume that hold is only toggled while SCK is low, so that no edge is made or lost when the freeze ends. The bench holds each SCK half period for six system clocks. It changes SI and hold only while SCK is low, and it changes write-protect only between selections. It checks that an internal write is gated on the synchronized write-protect level and write-enable latch from the cycle before busy rises. It checks that the sequence position stays frozen while hold is low. It also checks that the end of busy always leaves the write-enable latch clear.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [7:0] {
        CMD_SET_WE  = 8'h06,
        CMD_CLR_WE  = 8'h04,
        CMD_RD_STAT = 8'h05,
        CMD_WR_STAT = 8'h01,
        CMD_RD_MEM  = 8'h03,
        CMD_WR_MEM  = 8'h02
    } cmd_e;

    typedef enum logic [2:0] {
        PH_CMD, PH_ADDR, PH_RD_MEM, PH_WR_MEM, PH_RD_STAT, PH_WR_STAT, PH_DISCARD
    } phase_e;

    typedef struct packed {
        logic [1:0] prot;
        logic       we;
    } ctl_t;

    function automatic logic [7:0] status_byte(ctl_t c, logic busy);
        return {4'b0000, c.prot, c.we, busy};
    endfunction

    // protected region chosen by the two protection bits
    function automatic logic region_locked(logic [1:0] prot, logic [ADDR_W-1:0] a);
        case (prot)
            2'b00:   return 1'b0;
            2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
            2'b10:   return a[ADDR_W-1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic sel,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s,
    output logic wp_s,
    output logic hold_s
);
    // packed order {cs_n, hold_n, wp_n, sck, si}
    localparam logic [4:0] IDLE_LVL = 5'b11100;

    logic [4:0] stg [STAGES];
    logic [4:0] pins;
    logic       sck_d, cs_d;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stg[g] <= IDLE_LVL;
                else if (g == 0) stg[g] <= {cs_n, hold_n, wp_n, sck, si};
                else             stg[g] <= stg[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign pins = stg[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= pins[1];
            cs_d  <= pins[4];
        end
    end

    assign sel      = ~pins[4];
    assign hold_s   = pins[3];
    assign wp_s     = pins[2];
    assign si_s     = pins[0];
    assign cs_rise  = pins[4] & ~cs_d;
    assign sck_rise = pins[1] & ~sck_d & hold_s & sel;
    assign sck_fall = ~pins[1] & sck_d & hold_s & sel;

endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
    parameter int CYCLES = 64,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= CNT_W'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

    // R8: a started cycle shows busy on the next clock
    p_start_busy_r8: assert property (@(posedge clk) disable iff (rst) start |=> busy);
    // R8: busy ends right after the final count
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> !busy);

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import spi_eeprom_pkg::*;
#(
    parameter int PAGE_BYTES  = 4,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NB_W  = $clog2(PAGE_BYTES + 1);
    localparam int BI_W  = $clog2(PAGE_BYTES);

    logic sel, cs_rise, sck_rise, sck_fall, si_s, wp_s, hold_s;
    logic busy, done, start_prog;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n), .wp_n(wp_n),
        .sel(sel), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .si_s(si_s), .wp_s(wp_s), .hold_s(hold_s)
    );

    eeprom_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(start_prog), .busy(busy), .done(done)
    );

    phase_e              ph;
    ctl_t                ctl;
    logic [2:0]          bcnt;
    logic [7:0]          rx, rx_next, tx, stat_new;
    logic                so_q, is_read, stat_got, pend_stat, byte_done;
    logic [ADDR_W-1:0]   addr;
    logic [NB_W-1:0]     nbytes;
    logic [7:0]          wbuf [PAGE_BYTES];
    logic [7:0]          mem  [DEPTH];

    always_comb begin
        rx_next    = {rx[6:0], si_s};
        byte_done  = sck_rise && (bcnt == 3'd7);
        start_prog = cs_rise && wp_s && ctl.we && !busy && (bcnt == 3'd0) &&
                     ((ph == PH_WR_MEM && nbytes != '0) || (ph == PH_WR_STAT && stat_got));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_CMD; ctl <= '0; bcnt <= '0; rx <= '0; tx <= '0; so_q <= 1'b0;
            is_read <= 1'b0; stat_got <= 1'b0; pend_stat <= 1'b0; addr <= '0;
            nbytes <= '0; stat_new <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) wbuf[i] <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (start_prog) pend_stat <= (ph == PH_WR_STAT);
            if (done) begin
                ctl.we <= 1'b0;
                if (pend_stat) ctl.prot <= stat_new[3:2];
                else begin
                    for (int i = 0; i < PAGE_BYTES; i++)
                        if (NB_W'(i) < nbytes && !region_locked(ctl.prot, addr + ADDR_W'(i)))
                            mem[addr + ADDR_W'(i)] <= wbuf[i];
                end
            end
            if (!sel) begin
                ph <= PH_CMD; bcnt <= '0; so_q <= 1'b0;
                if (cs_rise) stat_got <= 1'b0;
            end else if (sck_fall) begin
                if (ph == PH_RD_MEM || ph == PH_RD_STAT) begin
                    so_q <= tx[7];
                    tx   <= {tx[6:0], 1'b0};
                end
            end else if (sck_rise) begin
                rx   <= rx_next;
                bcnt <= bcnt + 3'd1;
                if (byte_done) begin
                    unique case (ph)
                        PH_CMD: begin
                            ph <= PH_DISCARD;
                            if (rx_next == CMD_RD_STAT) begin
                                ph <= PH_RD_STAT;
                                tx <= status_byte(ctl, busy);
                            end else if (!busy) begin
                                case (rx_next)
                                    CMD_SET_WE:  ctl.we <= 1'b1;
                                    CMD_CLR_WE:  ctl.we <= 1'b0;
                                    CMD_WR_STAT: ph <= PH_WR_STAT;
                                    CMD_RD_MEM:  begin ph <= PH_ADDR; is_read <= 1'b1; end
                                    CMD_WR_MEM:  begin ph <= PH_ADDR; is_read <= 1'b0; end
                                    default: ;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            addr <= rx_next;
                            if (is_read) begin
                                ph <= PH_RD_MEM;
                                tx <= mem[rx_next];
                            end else begin
                                ph     <= PH_WR_MEM;
                                nbytes <= '0;
                            end
                        end
                        PH_RD_MEM: begin
                            addr <= addr + 1'b1;
                            tx   <= mem[addr + 1'b1];
                        end
                        PH_RD_STAT: tx <= status_byte(ctl, busy);
                        PH_WR_MEM: begin
                            if (nbytes < NB_W'(PAGE_BYTES)) begin
                                wbuf[nbytes[BI_W-1:0]] <= rx_next;
                                nbytes <= nbytes + 1'b1;
                            end
                        end
                        PH_WR_STAT: begin
                            stat_new <= rx_next;
                            stat_got <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign so = so_q;

    // R1: deselected means a quiet output
    p_so_quiet_r1: assert property (@(posedge clk) disable iff (rst) !sel |=> (so == 1'b0));
    // R10: hold low freezes the sequence position
    p_hold_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        (!hold_s && sel) |=> ($stable(bcnt) && $stable(ph)));
    // R5 and R6: a programming cycle only follows an unprotected, enabled request
    p_prog_gate_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wp_s) && $past(ctl.we)));
    // R12: no command can set the write-enable latch while busy
    p_busy_we_r12: assert property (@(posedge clk) disable iff (rst) (busy && !ctl.we) |=> !ctl.we);
    // R8: end of programming leaves the latch clear
    p_we_drop_r8: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> !ctl.we);

endmodule

// File: tb/sim_spi_eeprom_slave.sv
module sim_spi_eeprom_slave;
    localparam int HALF = 6;
    localparam int PROG = 800;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so;

    always #2 clk = ~clk;

    spi_eeprom_slave #(.PAGE_BYTES(4), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_q [$];
    logic [7:0] obs_q [$];
    string      tag_q [$];

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compares observed bytes against the scoreboard queue
    initial forever begin
        @(negedge clk);
        if (obs_q.size() > 0 && exp_q.size() > 0)
            check(tag_q.pop_front(), int'(obs_q.pop_front()), int'(exp_q.pop_front()));
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_hold();
        hold_n = 1'b0; si = 1'b1; wait_clk(HALF);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
        end
        hold_n = 1'b1; wait_clk(HALF);
    endtask

    task automatic xfer(input logic [7:0] d, output logic [7:0] r, input int hold_at, input int nb);
        r = '0;
        for (int b = 7; b >= 8 - nb; b--) begin
            if (b == hold_at) do_hold();
            si = d[b]; wait_clk(HALF);
            r[b] = so; sck = 1'b1; wait_clk(HALF); sck = 1'b0;
        end
    endtask

    task automatic open_sel();
        sck = 1'b0; cs_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic close_sel();
        wait_clk(HALF); cs_n = 1'b1; wait_clk(3 * HALF);
    endtask

    task automatic send_cmd(input logic [7:0] c);
        logic [7:0] r;
        open_sel(); xfer(c, r, -1, 8); close_sel();
    endtask

    task automatic rd_stat(input logic [7:0] e, input string tag, input int hold_at);
        logic [7:0] r;
        open_sel(); xfer(8'h05, r, hold_at, 8);
        exp_q.push_back(e); tag_q.push_back(tag);
        xfer(8'h00, r, -1, 8); obs_q.push_back(r);
        exp_q.push_back(e); tag_q.push_back({tag, " repeat"});
        xfer(8'h00, r, -1, 8); obs_q.push_back(r);
        close_sel();
    endtask

    task automatic wr_stat(input logic [7:0] v);
        logic [7:0] r;
        open_sel(); xfer(8'h01, r, -1, 8); xfer(v, r, -1, 8); close_sel();
    endtask

    task automatic wr_mem(input logic [7:0] a, input logic [63:0] d, input int n);
        logic [7:0] r;
        open_sel(); xfer(8'h02, r, -1, 8); xfer(a, r, -1, 8);
        for (int i = 0; i < n; i++) xfer(d[8*(n-1-i) +: 8], r, -1, 8);
        close_sel();
    endtask

    task automatic rd_mem(input logic [7:0] a, input logic [63:0] e, input int n, input string tag);
        logic [7:0] r;
        open_sel(); xfer(8'h03, r, -1, 8); xfer(a, r, -1, 8);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(e[8*(n-1-i) +: 8]); tag_q.push_back(tag);
            xfer(8'h00, r, -1, 8); obs_q.push_back(r);
        end
        close_sel();
    endtask

    task automatic wait_prog();
        wait_clk(PROG + 60);
    endtask

    task automatic finish_run();
        wait_clk(20);
        check("scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r;
        wait_clk(5); rst = 1'b0; wait_clk(5);
        check("R1 so idle after reset", so, 0);
        rd_stat(8'h00, "R4 reset status", -1);

        // R3 decode of enable set/clear and unknown command
        send_cmd(8'h06); rd_stat(8'h02, "R3 set write enable", -1);
        send_cmd(8'hA5); rd_stat(8'h02, "R3 unknown command ignored", -1);
        send_cmd(8'h04); rd_stat(8'h00, "R3 clear write enable", -1);

        // R5 write protect low; R14 enable still works
        wp_n = 1'b0; wait_clk(10);
        send_cmd(8'h06); rd_stat(8'h02, "R14 enable with protect low", -1);
        wr_mem(8'h40, 64'h5A, 1); rd_stat(8'h02, "R5 array write no busy", -1);
        rd_mem(8'h40, 64'h00, 1, "R5 array unchanged");
        wr_stat(8'h0C); rd_stat(8'h02, "R5 status write blocked", -1);
        wp_n = 1'b1; wait_clk(10);

        // R6 latch clear blocks writes
        send_cmd(8'h04);
        wr_mem(8'h40, 64'h5A, 1); rd_stat(8'h00, "R6 no busy without enable", -1);
        rd_mem(8'h40, 64'h00, 1, "R6 array unchanged");

        // R8 commit and R12 busy lockout
        send_cmd(8'h06);
        wr_mem(8'h10, 64'h5AA53C, 3);
        rd_stat(8'h03, "R8 busy after commit", -1);
        send_cmd(8'h04);
        rd_stat(8'h03, "R12 clear ignored while busy", -1);
        wait_prog();
        rd_stat(8'h00, "R8 busy and enable cleared", -1);
        rd_mem(8'h10, 64'h5AA53C, 3, "R2 R8 stored bytes");

        // R13 page limit and R11 read wrap
        send_cmd(8'h06);
        wr_mem(8'hFE, 64'h112233445566, 6); wait_prog();
        rd_mem(8'hFD, 64'h001122334400, 6, "R11 R13 wrap and page limit");

        // R8 partial byte stores nothing
        send_cmd(8'h06);
        open_sel(); xfer(8'h02, r, -1, 8); xfer(8'h20, r, -1, 8); xfer(8'hFF, r, -1, 4); close_sel();
        rd_stat(8'h02, "R8 partial byte no commit", -1);
        rd_mem(8'h20, 64'h00, 1, "R8 partial byte unchanged");

        // R9 protect drops after start; R14 reads with protect low
        wr_mem(8'h30, 64'h77, 1);
        wp_n = 1'b0; wait_clk(10);
        rd_stat(8'h03, "R14 status read with protect low", -1);
        wait_prog();
        rd_mem(8'h30, 64'h77, 1, "R9 write completed");
        rd_mem(8'h10, 64'h5A, 1, "R14 array read with protect low");
        wp_n = 1'b1; wait_clk(10);

        // R7 protected regions
        send_cmd(8'h06); wr_stat(8'h04); wait_prog();
        rd_stat(8'h04, "R4 R8 protect bits stored", -1);
        send_cmd(8'h06); wr_mem(8'hBF, 64'hA1A2, 2); wait_prog();
        rd_mem(8'hBF, 64'hA100, 2, "R7 upper quarter");
        send_cmd(8'h06); wr_stat(8'h08); wait_prog();
        send_cmd(8'h06); wr_mem(8'h7F, 64'hB1B2, 2); wait_prog();
        rd_mem(8'h7F, 64'hB100, 2, "R7 upper half");
        send_cmd(8'h06); wr_stat(8'h0C); wait_prog();
        rd_stat(8'h0C, "R4 full protect", -1);
        send_cmd(8'h06); wr_mem(8'h00, 64'h99, 1); wait_prog();
        rd_mem(8'h00, 64'h33, 1, "R7 whole array");
        send_cmd(8'h06); wr_stat(8'hF0); wait_prog();
        rd_stat(8'h00, "R4 upper bits read zero", -1);

        // R10 hold freezes mid command
        send_cmd(8'h06);
        rd_stat(8'h02, "R10 resume after hold", 3);

        // R1 abandoned sequence restarts at a command byte
        open_sel(); xfer(8'h03, r, -1, 8); xfer(8'h10, r, -1, 3); close_sel();
        check("R1 so quiet when deselected", so, 0);
        rd_stat(8'h02, "R1 fresh command after abort", -1);

        finish_run();
    end

endmodule